// File: doc/BRIEF.md
# Nine-bit SPI register writer

This block turns register-write requests into serial frames on a three-wire SPI link whose words are nine bits long. The top bit of every word says whether the remaining eight bits are a register address (command) or a data byte. A request names one register address and carries zero, one or two data bytes. The block sends the command word and then the data words back to back, all inside a single chip-select frame. It signals with a one-cycle pulse when the frame is finished, or with an error pulse when the request is malformed.

The requester sees a valid/ready port with an address byte, a two-bit byte count and a 16-bit data field. The serial clock comes from the system clock through a divider. The half-period length is taken from an input and latched when a request is accepted. The link runs in SPI mode 3: the clock idles high, the receiver samples on the rising edge, and MOSI moves only on falling edges.

The sequencer has seven states:
- IDLE: ready is high and a request is accepted.
- LEAD: chip select is low and the clock is high, for one half period.
- LOW: the clock is low and the current bit is on MOSI.
- HIGH: the clock is high and the receiver samples.
- TRAIL: chip select is still low after the last bit.
- GAP_A and GAP_B: chip select is high, for two half periods in total.

The transitions are:
- IDLE to LEAD, on a request with a valid byte count.
- LEAD to LOW, emitting the first bit of the command word.
- LOW to HIGH, when the half period ends.
- HIGH to LOW, with the next bit of the same word.
- HIGH to LOW, with the first bit of the next word.
- HIGH to TRAIL, after the last bit of the last word.
- TRAIL to GAP_A, releasing chip select.
- GAP_A to GAP_B.
- GAP_B to IDLE, with the done pulse.

A request whose byte count is 3 is consumed in IDLE and answered only with the error pulse.

Top module: `spi9_reg_writer`

## Requirements
- R1: Every serial word is 9 bits, sent most significant bit first. Bit 8 is 0 for the command (address) word and 1 for a data word, and bits 7..0 carry the byte.
- R2: A byte count of 0, 1 or 2 gives a frame of 1, 2 or 3 words. With a count of 1 the single data word carries req_data[7:0].
- R3: With a count of 2, the second word carries req_data[15:8] and the third word carries req_data[7:0].
- R4: A request with a byte count of 3 is consumed without a frame. err pulses high for one cycle, one cycle after acceptance, and chip select and ready stay high.
- R5: While chip select is high the serial clock is high, which is the mode 3 idle level.
- R6: MOSI changes only while the serial clock is low, so it is stable at every rising edge.
- R7: Chip select falls while the clock is high and stays low for the whole frame. After the last rising edge it stays low for two more half periods before it rises.
- R8: Between two frames chip select stays high for at least two half periods, which is one full serial clock period.
- R9: ready is low from the cycle after acceptance until the frame ends. done is a single-cycle pulse that comes while chip select is high and after it has been released.
- R10: Each low and high clock phase lasts sclk_half+1 system cycles. The value is latched at acceptance, so later changes on sclk_half do not affect the frame in flight.
- R11: After reset: chip select 1, clock 1, MOSI 0, ready 1, done 0, err 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 8 | Register address for the command word |
| req_nbytes | input | 2 | Number of data bytes (0, 1, 2; 3 is an error) |
| req_data | input | 16 | Data value; the low byte is used for one byte, both bytes for two |
| sclk_half | input | DIV_W | Half period of the serial clock minus one, in system cycles |
| spi_sclk | output | 1 | Serial clock, idles high |
| spi_mosi | output | 1 | Serial data out |
| spi_csn | output | 1 | Active-low chip select |
| done | output | 1 | One-cycle pulse when a frame is finished |
| err | output | 1 | One-cycle pulse when a request is rejected |

## Verification
The hardest point to reach is the HIGH phase at the end of a word. There the sequencer must choose between the next bit, the first bit of the next word, or the trailing hold, and the choice depends on the latched count. The stimulus table walks all three frame lengths across several half-period settings, using payloads whose top and bottom bits differ, so a word-boundary mistake shifts bits visibly. After each acceptance the bench also changes sclk_half, so a divider that does not latch its value shows up as wrong phase lengths.

// File: rtl/spi9_pkg.sv
package spi9_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = BYTE_W + 1;
    localparam int IDX_W     = 2;
    localparam int NUM_SLOTS = 1 << IDX_W;
    localparam int BITC_W    = $clog2(WORD_W + 1);

    localparam logic FLAG_CMD  = 1'b0;
    localparam logic FLAG_DATA = 1'b1;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_TRAIL,
        ST_GAP_A,
        ST_GAP_B
    } wr_state_e;

    function automatic word_t make_word(input logic flag, input logic [BYTE_W-1:0] payload);
        return {flag, payload};
    endfunction
endpackage

// File: rtl/spi9_half_timer.sv
module spi9_half_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [W-1:0] lim,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    assign tick = (cnt_q == lim);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi9_frame_store.sv
module spi9_frame_store
    import spi9_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load,
    input  logic [BYTE_W-1:0]     addr,
    input  logic [IDX_W-1:0]      nbytes,
    input  logic [2*BYTE_W-1:0]   data,
    input  logic [IDX_W-1:0]      rd_idx,
    output word_t                 rd_word,
    output logic [IDX_W-1:0]      last_idx
);
    word_t words_q [NUM_SLOTS];

    // Slot 0: command; slot 1: first data byte; slot 2: second data byte.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                words_q[i] <= '0;
            end
            last_idx <= '0;
        end else if (load) begin
            words_q[0] <= make_word(FLAG_CMD, addr);
            words_q[1] <= make_word(FLAG_DATA,
                                    (nbytes == IDX_W'(2)) ? data[2*BYTE_W-1:BYTE_W]
                                                          : data[BYTE_W-1:0]);
            words_q[2] <= make_word(FLAG_DATA, data[BYTE_W-1:0]);
            words_q[3] <= '0;
            last_idx   <= nbytes;
        end
    end

    assign rd_word = words_q[rd_idx];
endmodule

// File: rtl/spi9_shifter.sv
module spi9_shifter
    import spi9_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  start,
    input  logic  step,
    input  word_t word_in,
    output logic  mosi,
    output logic  last_bit
);
    logic [WORD_W-2:0] rest_q;
    logic [BITC_W-1:0] cnt_q;
    logic              mosi_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rest_q <= '0;
            cnt_q  <= '0;
            mosi_q <= 1'b0;
        end else if (start) begin
            mosi_q <= word_in[WORD_W-1];
            rest_q <= word_in[WORD_W-2:0];
            cnt_q  <= BITC_W'(1);
        end else if (step) begin
            mosi_q <= rest_q[WORD_W-2];
            rest_q <= {rest_q[WORD_W-3:0], 1'b0};
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign mosi     = mosi_q;
    assign last_bit = (cnt_q == BITC_W'(WORD_W));
endmodule

// File: rtl/spi9_reg_writer.sv
module spi9_reg_writer
    import spi9_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [BYTE_W-1:0]     req_addr,
    input  logic [IDX_W-1:0]      req_nbytes,
    input  logic [2*BYTE_W-1:0]   req_data,
    input  logic [DIV_W-1:0]      sclk_half,
    output logic                  spi_sclk,
    output logic                  spi_mosi,
    output logic                  spi_csn,
    output logic                  done,
    output logic                  err
);
    localparam logic [IDX_W-1:0] BAD_COUNT = '1;

    wr_state_e        state_q, state_d;
    logic [DIV_W-1:0] lim_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] last_idx;
    word_t            cur_word;
    logic             tick, last_bit;
    logic             shift_start, shift_step, idx_inc, fin;
    logic             accept_ok, reject;

    assign accept_ok = (state_q == ST_IDLE) && req_valid && (req_nbytes != BAD_COUNT);
    assign reject    = (state_q == ST_IDLE) && req_valid && (req_nbytes == BAD_COUNT);
    assign rd_idx    = (state_q == ST_HIGH) ? IDX_W'(idx_q + 1'b1) : '0;

    spi9_half_timer #(.W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (state_q == ST_IDLE),
        .lim   (lim_q),
        .tick  (tick)
    );

    spi9_frame_store u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept_ok),
        .addr     (req_addr),
        .nbytes   (req_nbytes),
        .data     (req_data),
        .rd_idx   (rd_idx),
        .rd_word  (cur_word),
        .last_idx (last_idx)
    );

    spi9_shifter u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (shift_start),
        .step     (shift_step),
        .word_in  (cur_word),
        .mosi     (spi_mosi),
        .last_bit (last_bit)
    );

    // Next-state logic
    always_comb begin
        state_d     = state_q;
        shift_start = 1'b0;
        shift_step  = 1'b0;
        idx_inc     = 1'b0;
        fin         = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (accept_ok) state_d = ST_LEAD;
            end
            ST_LEAD: begin
                if (tick) begin
                    state_d     = ST_LOW;
                    shift_start = 1'b1;
                end
            end
            ST_LOW: begin
                if (tick) state_d = ST_HIGH;
            end
            ST_HIGH: begin
                if (tick) begin
                    if (!last_bit) begin
                        state_d    = ST_LOW;
                        shift_step = 1'b1;
                    end else if (idx_q != last_idx) begin
                        state_d     = ST_LOW;
                        shift_start = 1'b1;
                        idx_inc     = 1'b1;
                    end else begin
                        state_d = ST_TRAIL;
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) state_d = ST_GAP_A;
            end
            ST_GAP_A: begin
                if (tick) state_d = ST_GAP_B;
            end
            ST_GAP_B: begin
                if (tick) begin
                    state_d = ST_IDLE;
                    fin     = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Registered outputs and frame bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done  <= 1'b0;
            err   <= 1'b0;
            idx_q <= '0;
            lim_q <= '0;
        end else begin
            done <= fin;
            err  <= reject;
            if (accept_ok) begin
                idx_q <= '0;
                lim_q <= sclk_half;
            end else if (idx_inc) begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign spi_sclk  = (state_q != ST_LOW);
    assign spi_csn   = (state_q == ST_IDLE) || (state_q == ST_GAP_A) || (state_q == ST_GAP_B);
endmodule

// File: rtl/spi9_reg_writer_chk.sv
module spi9_reg_writer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_valid,
    input logic       req_ready,
    input logic [1:0] req_nbytes,
    input logic       spi_sclk,
    input logic       spi_mosi,
    input logic       spi_csn,
    input logic       done,
    input logic       err
);
    AST_MOSI_ONLY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(spi_mosi) |-> !spi_sclk); // R6
    AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        spi_csn |-> spi_sclk); // R5
    AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        !spi_csn |-> !req_ready); // R9
    AST_DONE_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (spi_csn && $past(spi_csn))); // R9
    AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($past(req_valid) && ($past(req_nbytes) == 2'd3))); // R4
    AST_REJECT_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (spi_csn && req_ready)); // R4
    AST_CSN_FALL_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_csn) |-> (spi_sclk && $past(spi_sclk))); // R7
    AST_CSN_RISE_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_csn) |-> $past(spi_sclk)); // R7
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err)); // R9
endmodule

bind spi9_reg_writer spi9_reg_writer_chk u_chk (.*);

// File: tb/test_spi9_reg_writer.sv
`timescale 1ns/1ps
module test_spi9_reg_writer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_addr = '0;
    logic [1:0]  req_nbytes = '0;
    logic [15:0] req_data = '0;
    logic [7:0]  sclk_half = '0;
    logic        spi_sclk, spi_mosi, spi_csn, done, err;

    always #2 clk = ~clk;

    spi9_reg_writer i_spi9_reg_writer (.*);

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    // {addr, nbytes, data, half}
    localparam int NVEC = 8;
    localparam logic [33:0] VEC [NVEC] = '{
        {8'h11, 2'd0, 16'h0000, 8'd0},
        {8'hBC, 2'd1, 16'h0080, 8'd1},
        {8'hB8, 2'd2, 16'hFFF9, 8'd0},
        {8'hC3, 2'd2, 16'h2040, 8'd2},
        {8'hFF, 2'd1, 16'hAB55, 8'd3},
        {8'h00, 2'd0, 16'hFFFF, 8'd1},
        {8'h5A, 2'd2, 16'h00FF, 8'd1},
        {8'hA5, 2'd2, 16'hFF00, 8'd0}
    };

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [8:0] exp_word(input logic [7:0] a, input logic [1:0] nb,
                                            input logic [15:0] d, input int i);
        if (i == 0) return {1'b0, a};
        if (i == 1) return {1'b1, (nb == 2'd2) ? d[15:8] : d[7:0]};
        return {1'b1, d[7:0]};
    endfunction

    // Serial monitor
    logic [8:0] mon_words [4];
    logic [8:0] mon_cur = '0;
    int mon_nw = 0, mon_bits = 0, mon_frames = 0;
    int mon_low_run = 0, mon_hi_gap = 0, mon_tail = 0;
    int mon_phase_bad = 0, mon_mosi_bad = 0, mon_gap_bad = 0, mon_bit_bad = 0, mon_tail_bad = 0;
    int exp_half = 0, last_half = 0;
    bit had_frame = 0;
    logic prev_csn = 1'b1, prev_sclk = 1'b1, prev_mosi = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_csn && !spi_csn) begin
                mon_nw = 0; mon_bits = 0; mon_low_run = 0; mon_tail = 0;
                if (had_frame && mon_hi_gap < 2 * (last_half + 1)) mon_gap_bad++;
            end
            if (!spi_csn) begin
                if (spi_sclk && !prev_sclk) begin
                    mon_cur = {mon_cur[7:0], spi_mosi};
                    mon_bits++;
                    if (mon_low_run != exp_half + 1) mon_phase_bad++;
                    if (mon_bits == 9) begin
                        if (mon_nw < 4) mon_words[mon_nw] = mon_cur;
                        mon_nw++;
                        mon_bits = 0;
                    end
                    mon_tail = 0;
                end
                if (!spi_sclk) mon_low_run++; else mon_low_run = 0;
                if (spi_sclk) mon_tail++;
                if (spi_mosi != prev_mosi && spi_sclk) mon_mosi_bad++;
            end
            if (!prev_csn && spi_csn) begin
                mon_frames++;
                had_frame = 1;
                last_half = exp_half;
                if (mon_bits != 0) mon_bit_bad++;
                if (mon_tail != 2 * (exp_half + 1)) mon_tail_bad++;
            end
            if (spi_csn) mon_hi_gap++; else mon_hi_gap = 0;
            prev_csn  = spi_csn;
            prev_sclk = spi_sclk;
            prev_mosi = spi_mosi;
        end
    end

    task automatic run_req(input logic [7:0] a, input logic [1:0] nb, input logic [15:0] d,
                           input logic [7:0] h);
        bit seen;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_addr = a; req_nbytes = nb; req_data = d; sclk_half = h; exp_half = int'(h);
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        sclk_half = h ^ 8'h05; // R10: must not affect the frame in flight
        check(req_ready == 1'b0, "R9 ready low in frame", {31'd0, req_ready}, 32'd0);
        seen = 0;
        for (int k = 0; k < 20000 && !seen; k++) begin
            if (done) seen = 1; else @(negedge clk);
        end
        check(seen, "R9 done pulse", {31'd0, seen}, 32'd1);
        check(spi_csn == 1'b1, "R9 done after csn release", {31'd0, spi_csn}, 32'd1);
        check(mon_nw == int'(nb) + 1, "R2 word count", mon_nw, int'(nb) + 1);
        for (int i = 0; i <= int'(nb) && i < 4; i++) begin
            check(mon_words[i] == exp_word(a, nb, d, i), (i == 2) ? "R3 low byte word" :
                  (i == 1 && nb == 2'd2) ? "R3 high byte word" : "R1 R2 word value",
                  {23'd0, mon_words[i]}, {23'd0, exp_word(a, nb, d, i)});
        end
    endtask

    initial begin
        int fr;
        repeat (3) @(negedge clk);
        // R11 reset values
        check(spi_csn == 1'b1 && spi_sclk == 1'b1, "R11 csn/sclk in reset", {30'd0, spi_csn, spi_sclk}, 32'd3);
        check(spi_mosi == 1'b0 && done == 1'b0 && err == 1'b0, "R11 mosi/done/err in reset",
              {29'd0, spi_mosi, done, err}, 32'd0);
        check(req_ready == 1'b1, "R11 ready in reset", {31'd0, req_ready}, 32'd1);
        rst_n = 1'b1;
        @(negedge clk);
        check(spi_csn == 1'b1 && spi_sclk == 1'b1 && req_ready == 1'b1, "R11 R5 idle after reset",
              {29'd0, spi_csn, spi_sclk, req_ready}, 32'd7);

        for (int v = 0; v < NVEC; v++) begin
            run_req(VEC[v][33:26], VEC[v][25:24], VEC[v][23:8], VEC[v][7:0]);
        end

        // R4: byte count 3 rejected
        fr = mon_frames;
        @(negedge clk);
        req_addr = 8'h29; req_nbytes = 2'd3; req_data = 16'h1234; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check(err == 1'b1, "R4 err pulse", {31'd0, err}, 32'd1);
        check(req_ready == 1'b1 && spi_csn == 1'b1, "R4 ready and csn high",
              {30'd0, req_ready, spi_csn}, 32'd3);
        @(negedge clk);
        check(err == 1'b0, "R4 err single cycle", {31'd0, err}, 32'd0);
        repeat (20) @(negedge clk);
        check(mon_frames == fr && spi_csn == 1'b1, "R4 no frame", mon_frames, fr);

        // frame after a rejection still works
        run_req(8'h3A, 2'd1, 16'h0060, 8'd2);

        check(mon_phase_bad == 0, "R10 phase length", mon_phase_bad, 0);
        check(mon_mosi_bad == 0, "R6 mosi stable while sclk high", mon_mosi_bad, 0);
        check(mon_gap_bad == 0, "R8 gap between frames", mon_gap_bad, 0);
        check(mon_bit_bad == 0, "R1 whole words only", mon_bit_bad, 0);
        check(mon_tail_bad == 0, "R7 csn hold after last edge", mon_tail_bad, 0);
        check(mon_frames == NVEC + 1, "R2 frame count", mon_frames, NVEC + 1);

        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule